// File: doc/BRIEF.md
# SPI Memory Command Decoder

This block is the serial front end of a small byte-addressed store with a 9-bit address space (000h to 1FFh). An SPI master selects it by pulling chip-select low. The first byte of every selection is decoded as a command. The block keeps a private status byte that is not part of the address map. That byte holds a write-enable latch, block-protect and register-protect bits, a protect-enable bit and a busy flag. Memory traffic leaves the block on a simple synchronous port: a read strobe returns data on the next clock, and a write strobe stores one byte.

All serial inputs are oversampled by the system clock through synchronisers, so the whole block runs in one clock domain. Write data is collected in a small page buffer. The buffer is flushed to the memory port only when chip-select rises on a byte boundary. The busy flag then stays set for a fixed hold-off time. Protected addresses are skipped during the flush. The refresh command gives a one-clock request to the register file that sits outside this block.

Top module: `spi_mem_cmd`

## Requirements
- R1: The interface uses SPI mode 0, most significant bit first: data is sampled on the rising serial clock edge. `miso_oe` is low whenever chip-select is high and high while chip-select is low.
- R2: Opcode 05h returns the status byte and repeats it for every further byte while selected. The layout is: bit 7 protect-enable, bits 6:5 zero, bit 4 register-protect, bits 3:2 block-protect code, bit 1 write-enable latch, bit 0 busy. After reset the status byte is 00h.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it. No other command sets the latch.
- R4: Opcode 0000_A011b is a read. The address is {A, next byte}. Data bytes come from consecutive addresses and wrap from 1FFh to 000h.
- R5: A write opcode (0000_A010b) issued while the latch is clear changes no memory and does not set busy.
- R6: A write with the latch set stores its data bytes at consecutive addresses from {A, address byte}. It does so once chip-select rises on a byte boundary after at least one data byte. Only the first PAGE_BYTES data bytes are kept. The latch then clears and busy sets.
- R7: If chip-select rises part-way through a byte of a write, nothing is written and the latch stays set.
- R8: Block-protect code 00 protects nothing, 01 protects C0h to FFh, 10 protects 80h to FFh and 11 protects 00h to FFh. Protected bytes are skipped.
- R9: With register-protect set, addresses 120h to 1FFh are not written. Addresses 100h to 11Fh stay writable.
- R10: Opcode 01h followed by a byte loads status bits 7, 4, 3 and 2 and clears the latch, provided the latch is set. It is refused, and the latch is kept, when protect-enable is 1 and `wp_n` is low.
- R11: Busy stays set from a write commit until BUSY_CYCLES clocks after the last byte is written. While busy, every command except 05h is ignored.
- R12: Opcode 07h raises `refresh_req` for exactly one clock. It is ignored while busy.
- R13: Any other opcode has no effect on the status byte or the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| wp_n | input | 1 | Write-protect pin, low locks the status byte when protect-enable is set |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` (tri-state control) |
| mem_addr | output | 9 | Memory port address |
| mem_wdata | output | 8 | Memory port write data |
| mem_we | output | 1 | Memory port write strobe |
| mem_re | output | 1 | Memory port read strobe, data expected next clock |
| mem_rdata | input | 8 | Memory port read data |
| refresh_req | output | 1 | One-clock request to reload the registers at 120h to 125h |

## Verification
A wrong write-enable latch shows up on the next status read as a wrong bit 1. It also shows at the memory port, where a write is either dropped or accepted against the rules, and a read-back exposes that within one transaction. A wrong protection decode or a wrong address increment puts a byte at the wrong place or misses a byte. The scoreboard catches this on the following read of that range. A busy flag that clears too early or too late is seen on a status read taken during the hold-off, and also through a command issued in that window that should not take effect.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes, controller states and status-byte layout for the
// SPI memory command decoder. Assumes a 9-bit byte address space.
package spi_mem_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_RFSH = 8'h07;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT_IN,
        ST_STAT_OUT,
        ST_DRAIN
    } cmd_state_e;

    typedef struct packed {
        logic       wpen;
        logic       rprot;
        logic [1:0] bp;
        logic       wel;
    } stat_t;

    function automatic logic [7:0] pack_status(input stat_t s, input logic busy);
        return {s.wpen, 2'b00, s.rprot, s.bp, s.wel, busy};
    endfunction

endpackage

// File: rtl/spi_mem_shifter.sv
// Serial receive/transmit for SPI mode 0, MSB first.
// Oversamples cs_n/sclk/mosi with the system clock; assumes each
// serial clock half-period spans several system clocks.
module spi_mem_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sclk_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       sel_o,
    output logic       cs_rise_o,
    output logic       boundary_o,
    output logic       miso_o,
    output logic       miso_oe_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] cs_sync, sclk_sync, mosi_sync;
    logic          cs_d, sclk_d;
    logic [2:0]    bit_cnt;
    logic [6:0]    shreg;
    logic          cs_s, sclk_s, mosi_s, rise;

    assign cs_s   = cs_sync[LAST];
    assign sclk_s = sclk_sync[LAST];
    assign mosi_s = mosi_sync[LAST];
    assign rise   = sclk_s & ~sclk_d & ~cs_s;

    // Bring the serial lines into the clock domain and keep edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sync   <= '1;
            sclk_sync <= '0;
            mosi_sync <= '0;
            cs_d      <= 1'b1;
            sclk_d    <= 1'b0;
        end else begin
            cs_sync   <= {cs_sync[LAST-1:0], cs_n_i};
            sclk_sync <= {sclk_sync[LAST-1:0], sclk_i};
            mosi_sync <= {mosi_sync[LAST-1:0], mosi_i};
            cs_d      <= cs_s;
            sclk_d    <= sclk_s;
        end
    end

    // Shift in one bit per rising serial edge and flag each full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            rx_byte_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= rise && (bit_cnt == 3'd7);
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg   <= {shreg[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) rx_byte_o <= {shreg, mosi_s};
            end
        end
    end

    assign sel_o      = ~cs_s;
    assign cs_rise_o  = cs_s & ~cs_d;
    assign boundary_o = (bit_cnt == 3'd0);
    assign miso_oe_o  = ~cs_s;
    assign miso_o     = cs_s ? 1'b0 : tx_byte_i[3'd7 - bit_cnt];

endmodule

// File: rtl/spi_mem_protect.sv
// Combinational protection decode: block/register protection of one
// address, and the hardware lock of the status byte.
module spi_mem_protect #(
    parameter int          ADDR_W   = 9,
    parameter logic [8:0]  REG_BASE = 9'h120
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bp_i,
    input  logic              rprot_i,
    input  logic              wpen_i,
    input  logic              wp_n_i,
    output logic              addr_prot_o,
    output logic              stat_lock_o
);
    logic low_half;

    assign low_half = ~addr_i[ADDR_W-1];

    // Decide whether the address falls in a protected range.
    always_comb begin
        addr_prot_o = 1'b0;
        if (low_half) begin
            unique case (bp_i)
                2'b00: addr_prot_o = 1'b0;
                2'b01: addr_prot_o = &addr_i[ADDR_W-2:ADDR_W-3];
                2'b10: addr_prot_o = addr_i[ADDR_W-2];
                2'b11: addr_prot_o = 1'b1;
            endcase
        end else begin
            addr_prot_o = rprot_i && (addr_i >= REG_BASE);
        end
    end

    assign stat_lock_o = wpen_i & ~wp_n_i;

endmodule

// File: rtl/spi_mem_ctrl.sv
// Command state machine, status byte, write page buffer and flush engine.
// Assumes one-clock read latency on the memory port and that rx_valid
// only pulses while the device is selected.
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte_i,
    input  logic              rx_valid_i,
    input  logic              sel_i,
    input  logic              cs_rise_i,
    input  logic              boundary_i,
    input  logic              wp_n_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        tx_byte_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              refresh_o,
    output logic [7:0]        status_o
);
    localparam int IDX_W  = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    cmd_state_e        state;
    stat_t             stat;
    logic              a8, is_rd, wr_ok, flushing, rd_pend;
    logic [ADDR_W-1:0] addr_q, wbase, flush_addr;
    logic [CNT_W-1:0]  wcnt;
    logic [IDX_W-1:0]  fidx;
    logic [BUSY_W-1:0] busy_cnt;
    logic [7:0]        wbuf [PAGE_BYTES];
    logic [1:0]        wp_sync;
    logic              busy, addr_prot, stat_lock, is_mem_op;

    assign busy       = flushing | (busy_cnt != '0);
    assign status_o   = pack_status(stat, busy);
    assign flush_addr = wbase + ADDR_W'(fidx);
    assign is_mem_op  = (rx_byte_i[7:4] == 4'h0) && (rx_byte_i[2:1] == 2'b01);

    spi_mem_protect #(.ADDR_W(ADDR_W)) u_prot (
        .addr_i      (flush_addr),
        .bp_i        (stat.bp),
        .rprot_i     (stat.rprot),
        .wpen_i      (stat.wpen),
        .wp_n_i      (wp_sync[1]),
        .addr_prot_o (addr_prot),
        .stat_lock_o (stat_lock)
    );

    // Capture write data bytes into the page buffer.
    always_ff @(posedge clk) begin
        if (rx_valid_i && state == ST_WDATA && wr_ok && wcnt < CNT_W'(PAGE_BYTES))
            wbuf[wcnt[IDX_W-1:0]] <= rx_byte_i;
    end

    // Decode commands, keep status, and drive the memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OPCODE;
            stat        <= '0;
            a8          <= 1'b0;
            is_rd       <= 1'b0;
            wr_ok       <= 1'b0;
            flushing    <= 1'b0;
            rd_pend     <= 1'b0;
            addr_q      <= '0;
            wbase       <= '0;
            wcnt        <= '0;
            fidx        <= '0;
            busy_cnt    <= '0;
            tx_byte_o   <= '0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            mem_we_o    <= 1'b0;
            mem_re_o    <= 1'b0;
            refresh_o   <= 1'b0;
            wp_sync     <= 2'b11;
        end else begin
            wp_sync   <= {wp_sync[0], wp_n_i};
            mem_we_o  <= 1'b0;
            mem_re_o  <= 1'b0;
            refresh_o <= 1'b0;
            rd_pend   <= mem_re_o;
            if (rd_pend) tx_byte_o <= mem_rdata_i;

            if (!sel_i) state <= ST_OPCODE;

            if (cs_rise_i && state == ST_WDATA && wr_ok && boundary_i && wcnt != '0) begin
                flushing <= 1'b1;
                fidx     <= '0;
                stat.wel <= 1'b0;
            end

            if (flushing) begin
                if (!addr_prot) begin
                    mem_we_o    <= 1'b1;
                    mem_addr_o  <= flush_addr;
                    mem_wdata_o <= wbuf[fidx];
                end
                if (CNT_W'(fidx) + CNT_W'(1) == wcnt) begin
                    flushing <= 1'b0;
                    busy_cnt <= BUSY_W'(BUSY_CYCLES);
                end else begin
                    fidx <= fidx + IDX_W'(1);
                end
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - BUSY_W'(1);
            end

            if (rx_valid_i) begin
                unique case (state)
                    ST_OPCODE: begin
                        tx_byte_o <= '0;
                        if (busy && rx_byte_i != OP_RDSR) begin
                            state <= ST_DRAIN;
                        end else if (rx_byte_i == OP_RDSR) begin
                            tx_byte_o <= status_o;
                            state     <= ST_STAT_OUT;
                        end else if (rx_byte_i == OP_WREN) begin
                            stat.wel <= 1'b1;
                            state    <= ST_DRAIN;
                        end else if (rx_byte_i == OP_WRDI) begin
                            stat.wel <= 1'b0;
                            state    <= ST_DRAIN;
                        end else if (rx_byte_i == OP_WRSR) begin
                            state <= ST_STAT_IN;
                        end else if (rx_byte_i == OP_RFSH) begin
                            refresh_o <= 1'b1;
                            state     <= ST_DRAIN;
                        end else if (is_mem_op) begin
                            a8    <= rx_byte_i[3];
                            is_rd <= rx_byte_i[0];
                            wr_ok <= stat.wel;
                            wcnt  <= '0;
                            state <= ST_ADDR;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= {a8, rx_byte_i};
                        if (is_rd) begin
                            mem_addr_o <= {a8, rx_byte_i};
                            mem_re_o   <= 1'b1;
                            state      <= ST_RDATA;
                        end else begin
                            wbase <= {a8, rx_byte_i};
                            state <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        addr_q     <= addr_q + ADDR_W'(1);
                        mem_addr_o <= addr_q + ADDR_W'(1);
                        mem_re_o   <= 1'b1;
                    end
                    ST_WDATA: begin
                        if (wcnt < CNT_W'(PAGE_BYTES)) wcnt <= wcnt + CNT_W'(1);
                    end
                    ST_STAT_IN: begin
                        if (stat.wel && !stat_lock) begin
                            stat.wpen  <= rx_byte_i[7];
                            stat.rprot <= rx_byte_i[4];
                            stat.bp    <= rx_byte_i[3:2];
                            stat.wel   <= 1'b0;
                        end
                        state <= ST_DRAIN;
                    end
                    ST_STAT_OUT: tx_byte_o <= status_o;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_mem_cmd.sv
// Top of the SPI memory command decoder: serial shifter plus command
// controller. Assumes the system clock is several times the serial clock.
module spi_mem_cmd #(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              wp_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              refresh_req
);
    logic [7:0] rx_byte, tx_byte, status_w;
    logic       rx_valid, sel, cs_rise, boundary;

    spi_mem_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .mosi_i     (mosi),
        .tx_byte_i  (tx_byte),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid),
        .sel_o      (sel),
        .cs_rise_o  (cs_rise),
        .boundary_o (boundary),
        .miso_o     (miso),
        .miso_oe_o  (miso_oe)
    );

    spi_mem_ctrl #(
        .ADDR_W      (ADDR_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_byte_i   (rx_byte),
        .rx_valid_i  (rx_valid),
        .sel_i       (sel),
        .cs_rise_i   (cs_rise),
        .boundary_i  (boundary),
        .wp_n_i      (wp_n),
        .mem_rdata_i (mem_rdata),
        .tx_byte_o   (tx_byte),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .refresh_o   (refresh_req),
        .status_o    (status_w)
    );

endmodule

// File: rtl/spi_mem_cmd_chk.sv
// Property checker for spi_mem_cmd, attached with bind. Watches the
// memory port, output enable and the status byte.
module spi_mem_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso_oe,
    input logic       mem_we,
    input logic       mem_re,
    input logic [8:0] mem_addr,
    input logic       refresh_req,
    input logic [7:0] status
);
    logic blk_hit, reg_hit;

    // Independent view of the protected ranges from the status byte.
    always_comb begin
        blk_hit = !mem_addr[8] && ((status[3:2] == 2'b11) ||
                  (status[3:2] == 2'b10 && mem_addr[7]) ||
                  (status[3:2] == 2'b01 && mem_addr[7] && mem_addr[6]));
        reg_hit = mem_addr[8] && status[4] && (mem_addr[7:0] >= 8'h20);
    end

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !miso_oe); // R1
    AST_WE_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 9'd1); // R6
    AST_NO_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !blk_hit); // R8
    AST_NO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !reg_hit); // R9
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> status[0]); // R11
    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !status[0]); // R11
    AST_REFRESH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req); // R12

endmodule

bind spi_mem_cmd spi_mem_cmd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .miso_oe     (miso_oe),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .refresh_req (refresh_req),
    .status      (status_w)
);

// File: tb/sim_spi_mem_cmd.sv
// Scoreboard bench: driver tasks push expected read bytes, a monitor
// pops and compares the bytes captured from miso.
module sim_spi_mem_cmd;
    localparam int HALF  = 8;
    localparam int BUSY  = 1500;
    localparam int PAGE  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic       miso, miso_oe, mem_we, mem_re, refresh_req;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    int checks = 0, failures = 0, rf_cnt = 0, we_cnt = 0;
    logic done = 1'b0;
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    spi_mem_cmd #(.PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .refresh_req(refresh_req)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    // Memory model with one-clock read latency; counts strobes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
        if (rst_n && refresh_req) rf_cnt <= rf_cnt + 1;
        if (rst_n && mem_we) we_cnt <= we_cnt + 1;
    end

    // Monitor: compare captured bytes against the expected queue.
    always @(negedge clk) begin
        if (act_q.size() != 0 && exp_q.size() != 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s read byte actual=%02h expected=%02h", t, a, e);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk); cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r;
        xbits(tx, 8, r);
    endtask

    task automatic expect_rd(input logic [7:0] e, input string tag);
        logic [7:0] r;
        exp_q.push_back(e); tag_q.push_back(tag);
        xbits(8'h00, 8, r);
        act_q.push_back(r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); send(op); cs_hi();
    endtask

    task automatic rdsr(input logic [7:0] e, input string tag);
        cs_lo(); send(8'h05); expect_rd(e, tag); expect_rd(e, tag); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        cs_lo(); send(8'h01); send(v); cs_hi();
    endtask

    task automatic mem_read(input logic [8:0] a, input int n, input string tag);
        cs_lo(); send({4'h0, a[8], 3'b011}); send(a[7:0]);
        for (int k = 0; k < n; k++) expect_rd(exp_mem[9'(a + 9'(k))], tag);
        cs_hi();
    endtask

    task automatic mem_write(input logic [8:0] a, input logic [7:0] d [6], input int n);
        cs_lo(); send({4'h0, a[8], 3'b010}); send(a[7:0]);
        for (int k = 0; k < n; k++) send(d[k]);
        cs_hi();
    endtask

    task automatic wait_idle();
        repeat (BUSY + 200) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [6];
        logic [7:0] r;
        int rf0, we0;
        for (int i = 0; i < 512; i++) exp_mem[i] = pat(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state
        chk("R1 oe idle", miso_oe, 0);
        chk("R12 refresh idle", refresh_req, 0);
        cs_lo();
        chk("R1 oe selected", miso_oe, 1);
        cs_hi();
        rdsr(8'h00, "R2 reset status");

        // Reads with 9th bit from opcode and wrap
        mem_read(9'h1FE, 3, "R4 wrap");
        mem_read(9'h021, 2, "R4 low");

        // Write without latch
        d = '{8'hAA, 0, 0, 0, 0, 0};
        mem_write(9'h010, d, 1);
        repeat (50) @(negedge clk);
        mem_read(9'h010, 1, "R5 no write");
        rdsr(8'h00, "R5 no busy");

        // Latch set/clear
        cmd1(8'h06); rdsr(8'h02, "R3 set");
        cmd1(8'h04); rdsr(8'h00, "R3 clear");
        cmd1(8'h06);

        // Committed write in upper half, then busy behaviour
        d = '{8'h11, 8'h22, 0, 0, 0, 0};
        rf0 = rf_cnt;
        mem_write(9'h130, d, 2);
        exp_mem[9'h130] = 8'h11; exp_mem[9'h131] = 8'h22;
        rdsr(8'h01, "R11 busy and R6 latch cleared");
        cmd1(8'h06);
        cmd1(8'h07);
        chk("R12 refresh ignored busy", rf_cnt, rf0);
        wait_idle();
        rdsr(8'h00, "R11 command ignored while busy");
        mem_read(9'h130, 2, "R6 stored");

        // Page limit
        cmd1(8'h06);
        d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
        mem_write(9'h060, d, 6);
        for (int k = 0; k < PAGE; k++) exp_mem[9'h060 + k] = d[k];
        wait_idle();
        mem_read(9'h060, 6, "R6 page limit");

        // Partial byte at deselect
        cmd1(8'h06);
        cs_lo(); send(8'h02); send(8'h40); send(8'h55); xbits(8'hF0, 4, r); cs_hi();
        repeat (50) @(negedge clk);
        mem_read(9'h040, 1, "R7 nothing written");
        rdsr(8'h02, "R7 latch kept");

        // Status writes and hardware lock
        wrsr(8'h84); rdsr(8'h84, "R10 accepted");
        wp_n = 1'b0;
        cmd1(8'h06); wrsr(8'h10); rdsr(8'h86, "R10 locked");
        wp_n = 1'b1;
        wrsr(8'h84); rdsr(8'h84, "R10 unlocked");

        // Block protect 01, then 11
        cmd1(8'h06);
        d = '{8'h5A, 8'hA5, 0, 0, 0, 0};
        mem_write(9'h0BF, d, 2);
        exp_mem[9'h0BF] = 8'h5A;
        wait_idle();
        mem_read(9'h0BF, 2, "R8 code 01");
        cmd1(8'h06); wrsr(8'h0C); rdsr(8'h0C, "R10 bp load");
        cmd1(8'h06);
        d = '{8'h66, 0, 0, 0, 0, 0};
        mem_write(9'h005, d, 1);
        wait_idle();
        cmd1(8'h06);
        d = '{8'h77, 0, 0, 0, 0, 0};
        mem_write(9'h105, d, 1);
        exp_mem[9'h105] = 8'h77;
        wait_idle();
        mem_read(9'h005, 1, "R8 code 11");
        mem_read(9'h105, 1, "R8 upper free");

        // Register protect
        cmd1(8'h06); wrsr(8'h10); rdsr(8'h10, "R9 rprot set");
        cmd1(8'h06);
        d = '{8'h01, 8'h02, 0, 0, 0, 0};
        mem_write(9'h11F, d, 2);
        exp_mem[9'h11F] = 8'h01;
        wait_idle();
        mem_read(9'h11F, 2, "R9 boundary");

        // Refresh pulse
        rf0 = rf_cnt;
        cmd1(8'h07);
        repeat (5) @(negedge clk);
        chk("R12 refresh pulse", rf_cnt, rf0 + 1);

        // Unknown opcode
        cmd1(8'h06);
        we0 = we_cnt;
        cs_lo(); send(8'hFF); send(8'h00); send(8'h00); cs_hi();
        rdsr(8'h12, "R13 status unchanged");
        chk("R13 no memory write", we_cnt, we0);
        chk("R1 oe after deselect", miso_oe, 0);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule